// File: doc/BRIEF.md
# USB controller reset and power-up sequencer

This block is a hardware state machine that brings a USB controller wrapper out of reset in a fixed, safe order. After a start request, and only while the configuration-valid flag is high, it holds every reset asserted, turns on the HS and SS PHY power and the SuperSpeed reference, and then releases the wrapper reset and the host-core reset one at a time. Each step is separated by a counted wait of controller-clock cycles. Port power control is set up between the two resets. The interface clock is then enabled and the mode bit is forced to host. The PHY reset is released last, and a done flag marks the end.

The wait length is a parameter. A synchronous abort drops the block back to its idle state from any point, with all resets asserted and all power off. Start requests that arrive while a sequence is running, or after it has completed, have no effect.

Top module: `usb_pwrup_seq`

## Requirements
- R1: After reset, and in idle, the outputs are: phy_rst_o=1, wrap_rst_o=1, core_rst_o=1, hs_pwr_o=0, ss_pwr_o=0, ss_ref_en_o=0, port_pwr_ctl_o=0, if_clk_en_o=0, dev_mode_o=1 (device), done_o=0.
- R2: A start_i pulse is accepted only in idle with cfg_ok_i=1. A start with cfg_ok_i=0 leaves every output at its idle value.
- R3: In the first cycle after an accepted start, all three resets are asserted and power is off. For the next W cycles, hs_pwr_o, ss_pwr_o and ss_ref_en_o are 1 while all resets stay asserted.
- R4: After that window, wrap_rst_o drops to 0 for a window of W cycles with core_rst_o still 1. One further cycle follows with port_pwr_ctl_o raised, and port_pwr_ctl_o then stays 1.
- R5: core_rst_o then drops to 0. After W more cycles, if_clk_en_o goes to 1 and dev_mode_o goes to 0 (host) for one cycle, ahead of the final step.
- R6: In the final step, phy_rst_o drops to 0 and done_o rises. The block holds this state until abort. done_o is 0 in every earlier cycle.
- R7: start_i pulses during a running sequence, or after done, do not change any output.
- R8: abort_i=1 at a clock edge forces every output to its R1 value in the next cycle, whatever the step.
- R9: W equals the WAIT_CYC parameter, except that values below 10 are raised to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the power-up sequence |
| cfg_ok_i | input | 1 | Configuration is valid; qualifies start |
| abort_i | input | 1 | Synchronous return to idle |
| phy_rst_o | output | 1 | PHY reset, active high |
| wrap_rst_o | output | 1 | Wrapper reset, active high |
| core_rst_o | output | 1 | Host-core reset, active high |
| hs_pwr_o | output | 1 | High-speed PHY power enable |
| ss_pwr_o | output | 1 | SuperSpeed PHY power enable |
| ss_ref_en_o | output | 1 | SuperSpeed reference clock enable |
| port_pwr_ctl_o | output | 1 | Port power control configured |
| if_clk_en_o | output | 1 | Interface clock enable |
| dev_mode_o | output | 1 | Mode: 1 device, 0 host |
| done_o | output | 1 | Sequence complete |

## Verification
On every cycle, the assertions check the ordering invariants. The wrapper is never out of reset without power and reference. The core is never out of reset while the wrapper is in reset or port power is unconfigured. The clock enable implies the core is released. done implies every reset is released. An abort always lands in the idle state, and the wait counter never passes its limit. The exact length of each window, the clamp of short waits to 10 cycles, and the fact that start is ignored while busy or unconfigured can only be shown by the bench. It compares a cycle-by-cycle expected timeline against the outputs.

// File: rtl/usb_pwrup_pkg.sv
package usb_pwrup_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ARM  = 3'd1,
    SQ_PWR  = 3'd2,
    SQ_WRAP = 3'd3,
    SQ_PPC  = 3'd4,
    SQ_CORE = 3'd5,
    SQ_CLK  = 3'd6,
    SQ_DONE = 3'd7
  } seq_st_e;

  typedef struct packed {
    logic phy_rst;
    logic wrap_rst;
    logic core_rst;
    logic hs_pwr;
    logic ss_pwr;
    logic ss_ref;
    logic port_pwr;
    logic if_clk;
    logic dev_mode;
    logic done;
  } seq_out_t;

  localparam int unsigned MIN_WAIT = 10;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned WAIT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  import usb_pwrup_pkg::*;

  localparam int unsigned EFF_WAIT = (WAIT_CYC < MIN_WAIT) ? MIN_WAIT : WAIT_CYC;
  localparam int unsigned CW       = $clog2(EFF_WAIT + 1);
  localparam logic [CW-1:0] LAST   = CW'(EFF_WAIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire_o = run_i && (cnt_q == LAST);
  assign cnt_en   = run_i || (cnt_q != '0);

  always_comb begin
    if (!run_i || expire_o) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    cfg_ok_i,
  input  logic                    abort_i,
  input  logic                    expire_i,
  output usb_pwrup_pkg::seq_st_e  st_o,
  output logic                    run_o
);
  import usb_pwrup_pkg::*;

  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (start_i && cfg_ok_i) st_d = SQ_ARM;
      SQ_ARM:  st_d = SQ_PWR;
      SQ_PWR:  if (expire_i) st_d = SQ_WRAP;
      SQ_WRAP: if (expire_i) st_d = SQ_PPC;
      SQ_PPC:  st_d = SQ_CORE;
      SQ_CORE: if (expire_i) st_d = SQ_CLK;
      SQ_CLK:  st_d = SQ_DONE;
      SQ_DONE: st_d = SQ_DONE;
      default: st_d = SQ_IDLE;
    endcase
    if (abort_i) st_d = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign st_o  = st_q;
  assign run_o = (st_q == SQ_PWR) || (st_q == SQ_WRAP) || (st_q == SQ_CORE);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_DONE && !abort_i) |=> (st_q == SQ_DONE));

endmodule

// File: rtl/seq_out_dec.sv
module seq_out_dec (
  input  usb_pwrup_pkg::seq_st_e  st_i,
  output usb_pwrup_pkg::seq_out_t out_o
);
  import usb_pwrup_pkg::*;

  always_comb begin
    out_o.phy_rst  = (st_i != SQ_DONE);
    out_o.wrap_rst = (st_i == SQ_IDLE) || (st_i == SQ_ARM) || (st_i == SQ_PWR);
    out_o.core_rst = (st_i < SQ_CORE);
    out_o.hs_pwr   = (st_i >= SQ_PWR);
    out_o.ss_pwr   = (st_i >= SQ_PWR);
    out_o.ss_ref   = (st_i >= SQ_PWR);
    out_o.port_pwr = (st_i >= SQ_PPC);
    out_o.if_clk   = (st_i >= SQ_CLK);
    out_o.dev_mode = (st_i < SQ_CLK);
    out_o.done     = (st_i == SQ_DONE);
  end

endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq #(
  parameter int unsigned WAIT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cfg_ok_i,
  input  logic abort_i,
  output logic phy_rst_o,
  output logic wrap_rst_o,
  output logic core_rst_o,
  output logic hs_pwr_o,
  output logic ss_pwr_o,
  output logic ss_ref_en_o,
  output logic port_pwr_ctl_o,
  output logic if_clk_en_o,
  output logic dev_mode_o,
  output logic done_o
);
  import usb_pwrup_pkg::*;

  seq_st_e  st;
  seq_out_t ov;
  logic     run, expire;

  seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cfg_ok_i (cfg_ok_i),
    .abort_i  (abort_i),
    .expire_i (expire),
    .st_o     (st),
    .run_o    (run)
  );

  seq_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .expire_o (expire)
  );

  seq_out_dec u_dec (
    .st_i  (st),
    .out_o (ov)
  );

  assign phy_rst_o      = ov.phy_rst;
  assign wrap_rst_o     = ov.wrap_rst;
  assign core_rst_o     = ov.core_rst;
  assign hs_pwr_o       = ov.hs_pwr;
  assign ss_pwr_o       = ov.ss_pwr;
  assign ss_ref_en_o    = ov.ss_ref;
  assign port_pwr_ctl_o = ov.port_pwr;
  assign if_clk_en_o    = ov.if_clk;
  assign dev_mode_o     = ov.dev_mode;
  assign done_o         = ov.done;

  // R3
  wrap_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_rst_o |-> (hs_pwr_o && ss_pwr_o && ss_ref_en_o));

  // R4
  core_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_o |-> (!wrap_rst_o && port_pwr_ctl_o));

  // R5
  clk_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_clk_en_o |-> (!core_rst_o && !dev_mode_o));

  // R6
  done_all_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!phy_rst_o && !wrap_rst_o && !core_rst_o && if_clk_en_o));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (phy_rst_o && wrap_rst_o && core_rst_o && !hs_pwr_o &&
                 !ss_pwr_o && !ss_ref_en_o && !done_o));

endmodule

// File: tb/sim_usb_pwrup_seq.sv
`timescale 1ns/1ps
module sim_usb_pwrup_seq;

  localparam int W0 = 12;  // u0 wait
  localparam int W1 = 10;  // u1 built with 3, expected clamp to 10

  logic clk = 0, rst_n = 0, start_i = 0, cfg_ok_i = 0, abort_i = 0;
  logic phy_rst, wrap_rst, core_rst, hs_pwr, ss_pwr, ss_ref, port_pwr, if_clk, dev_mode, done;
  logic b_phy, b_wrap, b_core, b_hs, b_ss, b_ref, b_pp, b_clk, b_mode, b_done;

  always #2.5 clk = ~clk;

  usb_pwrup_seq #(.WAIT_CYC(W0)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_ok_i(cfg_ok_i), .abort_i(abort_i),
    .phy_rst_o(phy_rst), .wrap_rst_o(wrap_rst), .core_rst_o(core_rst), .hs_pwr_o(hs_pwr),
    .ss_pwr_o(ss_pwr), .ss_ref_en_o(ss_ref), .port_pwr_ctl_o(port_pwr), .if_clk_en_o(if_clk),
    .dev_mode_o(dev_mode), .done_o(done));

  usb_pwrup_seq #(.WAIT_CYC(3)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_ok_i(cfg_ok_i), .abort_i(abort_i),
    .phy_rst_o(b_phy), .wrap_rst_o(b_wrap), .core_rst_o(b_core), .hs_pwr_o(b_hs),
    .ss_pwr_o(b_ss), .ss_ref_en_o(b_ref), .port_pwr_ctl_o(b_pp), .if_clk_en_o(b_clk),
    .dev_mode_o(b_mode), .done_o(b_done));

  typedef struct {
    logic [9:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  // {phy,wrap,core,hs,ss,ref,pp,clk,mode,done}
  localparam logic [9:0] V_IDLE = 10'b1110000010;
  localparam logic [9:0] V_PWR  = 10'b1111110010;
  localparam logic [9:0] V_WRAP = 10'b1011110010;
  localparam logic [9:0] V_PPC  = 10'b1011111010;
  localparam logic [9:0] V_CORE = 10'b1001111010;
  localparam logic [9:0] V_CLK  = 10'b1001111100;
  localparam logic [9:0] V_DONE = 10'b0001111101;

  function automatic logic [9:0] obs();
    return {phy_rst, wrap_rst, core_rst, hs_pwr, ss_pwr, ss_ref, port_pwr, if_clk, dev_mode, done};
  endfunction

  // Expected output for sample k (k=1 is the first cycle after start was taken)
  function automatic exp_t ideal(int k, int w);
    exp_t e;
    if (k == 1)                begin e.v = V_IDLE; e.tag = "R3"; end
    else if (k <= w + 1)       begin e.v = V_PWR;  e.tag = "R3"; end
    else if (k <= 2*w + 1)     begin e.v = V_WRAP; e.tag = "R4"; end
    else if (k == 2*w + 2)     begin e.v = V_PPC;  e.tag = "R4"; end
    else if (k <= 3*w + 2)     begin e.v = V_CORE; e.tag = "R5"; end
    else if (k == 3*w + 3)     begin e.v = V_CLK;  e.tag = "R5"; end
    else                       begin e.v = V_DONE; e.tag = "R6"; end
    return e;
  endfunction

  task automatic check(bit ok, string tag, logic [9:0] act, logic [9:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops one expectation per cycle, just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check(obs() === e.v, e.tag, obs(), e.v);
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic push_idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e; e.v = V_IDLE; e.tag = tag; q.push_back(e);
    end
  endtask

  // Driver: start a sequence and queue n samples of the ideal timeline
  task automatic run_seq(int n);
    @(negedge clk);
    start_i = 1; cfg_ok_i = 1;
    for (int k = 1; k <= n; k++) q.push_back(ideal(k, W0));
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic do_abort();
    drain();
    abort_i = 1;
    push_idle(1, "R8");
    @(negedge clk);
    abort_i = 0;
    push_idle(2, "R8");
    drain();
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1: outputs held at idle values in reset
    check(obs() === V_IDLE, "R1", obs(), V_IDLE);
    rst_n = 1;
    push_idle(3, "R1");
    drain();

    // R2: start without valid configuration is ignored
    start_i = 1; cfg_ok_i = 0;
    push_idle(4, "R2");
    @(negedge clk); start_i = 0;
    drain();

    // Full sequence, with stray start pulses inside it (R7)
    run_seq(3*W0 + 8);
    repeat (5) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (W0 + 3) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    drain();
    // R7: start after done keeps done state
    start_i = 1;
    for (int i = 0; i < 3; i++) begin
      exp_t e; e.v = V_DONE; e.tag = "R7"; q.push_back(e);
    end
    @(negedge clk); start_i = 0;
    drain();
    // R8: abort from done
    do_abort();

    // R8: aborts in the wrapper and core windows
    run_seq(W0 + 5);
    do_abort();
    run_seq(2*W0 + 6);
    do_abort();

    // R9: short wait parameter is raised to 10 on u1
    @(negedge clk);
    start_i = 1; cfg_ok_i = 1;
    @(negedge clk);
    start_i = 0;
    cyc = 1;
    while (!b_done && cyc < 200) begin @(negedge clk); cyc++; end
    check(cyc == 3*W1 + 4, "R9", 10'(cyc), 10'(3*W1 + 4));
    do_abort();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule